// File: doc/BRIEF.md
# Flagged 32-bit Integer Multiplier

This block multiplies two 32-bit operands and returns the product together with a six-bit status vector in the style of a general-purpose processor's arithmetic flags. Two result forms are offered. The widening form returns the full 64-bit product as a low word and a high word, and it treats the operands as unsigned or signed as the caller chooses. The truncating form serves the register-times-register and register-times-constant multiplies that keep only 32 bits. It is always signed, and its high word reads as zero.

Carry and overflow report whether the product fits in the low word. For unsigned operands, that means the high word is zero. For signed operands, it means the 64-bit product equals the sign-extension of its own low word. Sign, zero and parity are derived from the low word in the same way as for a logical operation. The auxiliary flag is always cleared.

Operands enter through a valid/ready handshake. An accepted operation takes one busy cycle, and its registered result is then presented for exactly one cycle.

Top module: `mulflag_unit`

## Requirements
- R1: In unsigned widening mode (`op_signed`=0, `op_form`=0), both operands are zero-extended. `res_lo` and `res_hi` return bits 31:0 and 63:32 of the 64-bit product.
- R2: In unsigned widening mode, carry (`res_flags[0]`) and overflow (`res_flags[5]`) are both 1 when `res_hi` is nonzero. Otherwise both are 0.
- R3: In signed widening mode (`op_signed`=1, `op_form`=0), both operands are sign-extended to 64 bits before the multiply, and both product halves are returned.
- R4: In signed mode, carry and overflow are both 1 exactly when the 64-bit product differs from the sign-extension of its low 32 bits.
- R5: In truncating mode (`op_form`=1), the operands are treated as signed whatever the value of `op_signed`. `res_lo` holds the low product word, `res_hi` reads 0, and carry and overflow follow the signed fit rule of R4.
- R6: Sign (`res_flags[4]`) equals bit 31 of `res_lo`. Zero (`res_flags[3]`) is 1 when `res_lo` is 0. Parity (`res_flags[1]`) is 1 when bits 7:0 of `res_lo` hold an even number of ones.
- R7: The auxiliary flag (`res_flags[2]`) is 0 for every result.
- R8: `in_ready` is 1 when the unit is idle, and an operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the one cycle after acceptance, and `in_valid` is ignored in that cycle. `out_valid` is then 1 for exactly one cycle, from the second edge after acceptance.
- R9: After synchronous reset, `out_valid` is 0, `in_ready` is 1, and `res_lo`, `res_hi` and `res_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands presented |
| in_ready | output | 1 | Unit can accept operands |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_signed | input | 1 | 1 selects signed operands in widening form |
| op_form | input | 1 | 0 selects widening form, 1 selects truncating form |
| out_valid | output | 1 | One-cycle result strobe |
| res_lo | output | 32 | Low product word |
| res_hi | output | 32 | High product word (0 in truncating form) |
| res_flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
The assertions assume that `op_signed` and `op_form` are stable on the accepting edge and that the caller does not depend on `in_valid` being held once the operands are taken. The timing properties also assume that reset is not raised between acceptance and the result strobe. The stimulus drives all inputs on the falling edge. It asserts `in_valid` only while `in_ready` is high, except in one scenario that deliberately keeps `in_valid` high through the busy cycle. Reset is applied only at the start of the run.

// File: rtl/mulflag_pkg.sv
package mulflag_pkg;

  // Flag vector: bit 0 carry, 1 parity, 2 aux, 3 zero, 4 sign, 5 overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } mul_flags_t;

  localparam int FLAG_BITS = $bits(mul_flags_t);

endpackage

// File: rtl/mulflag_mult.sv
module mulflag_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sext,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  // Extend each operand to full product width, by sign or by zero
  assign a_ext = {{W{sext & a[W-1]}}, a};
  assign b_ext = {{W{sext & b[W-1]}}, b};

  // Product modulo 2^PW is correct for both interpretations
  assign prod = a_ext * b_ext;

endmodule

// File: rtl/mulflag_flags.sv
module mulflag_flags
  import mulflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           sext,
  output mul_flags_t     flags
);

  localparam int PAR_W = (W < 8) ? W : 8;

  logic [W-1:0] lo;
  logic [W-1:0] hi;
  logic         no_fit;

  assign lo = prod[W-1:0];
  assign hi = prod[2*W-1:W];

  // Signed: upper half must replicate the low word's sign bit
  // Unsigned: upper half must be zero
  assign no_fit = sext ? (hi != {W{lo[W-1]}}) : (|hi);

  always_comb begin
    flags     = '0;
    flags.cry = no_fit;
    flags.ovf = no_fit;
    flags.sgn = lo[W-1];
    flags.zro = (lo == '0);
    flags.par = ~^lo[PAR_W-1:0];
    flags.aux = 1'b0;
  end

endmodule

// File: rtl/mulflag_unit.sv
module mulflag_unit
  import mulflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic                 op_signed,
  input  logic                 op_form,
  output logic                 out_valid,
  output logic [W-1:0]         res_lo,
  output logic [W-1:0]         res_hi,
  output logic [FLAG_BITS-1:0] res_flags
);

  logic         busy;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic         sext_q;
  logic         trunc_q;
  logic         take;

  logic [2*W-1:0] prod;
  mul_flags_t     fl;

  assign in_ready = ~busy;
  assign take     = in_valid & ~busy;

  // Operand capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      sext_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else if (take) begin
      busy    <= 1'b1;
      a_q     <= op_a;
      b_q     <= op_b;
      sext_q  <= op_signed | op_form;
      trunc_q <= op_form;
    end else begin
      busy    <= 1'b0;
    end
  end

  mulflag_mult #(.W(W)) u_mult (
    .a    (a_q),
    .b    (b_q),
    .sext (sext_q),
    .prod (prod)
  );

  mulflag_flags #(.W(W)) u_flags (
    .prod  (prod),
    .sext  (sext_q),
    .flags (fl)
  );

  // Result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      res_flags <= '0;
    end else if (busy) begin
      out_valid <= 1'b1;
      res_lo    <= prod[W-1:0];
      res_hi    <= trunc_q ? '0 : prod[2*W-1:W];
      res_flags <= fl;
    end else begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mulflag_unit_chk.sv
module mulflag_unit_chk #(
  parameter int W  = 32,
  parameter int FB = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          op_signed,
  input logic          op_form,
  input logic          out_valid,
  input logic [W-1:0]  res_lo,
  input logic [W-1:0]  res_hi,
  input logic [FB-1:0] res_flags
);

  logic acc;
  assign acc = in_valid & in_ready;

  // R8: strobe lasts one cycle
  a_r8_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: busy for the cycle after acceptance
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    acc |=> !in_ready);

  // R8: result arrives two edges after acceptance
  a_r8_result_latency: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 out_valid);

  // R2, R4: carry and overflow agree
  a_r4_carry_eq_ovf: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (res_flags[0] == res_flags[5]));

  // R2: unsigned widening fit rule
  a_r2_unsigned_fit: assert property (@(posedge clk) disable iff (rst)
    (acc && !op_signed && !op_form) |-> ##2 (res_flags[0] == (res_hi != '0)));

  // R5: truncating form clears high word
  a_r5_trunc_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && op_form) |-> ##2 (res_hi == '0));

  // R6: zero and sign flags follow the low word
  a_r6_zero_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (res_flags[3] == (res_lo == '0)) && (res_flags[4] == res_lo[W-1]));

  // R7: auxiliary flag never set
  a_r7_aux_clear: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !res_flags[2]);

endmodule

bind mulflag_unit mulflag_unit_chk #(.W(W), .FB(mulflag_pkg::FLAG_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_signed (op_signed),
  .op_form   (op_form),
  .out_valid (out_valid),
  .res_lo    (res_lo),
  .res_hi    (res_hi),
  .res_flags (res_flags)
);

// File: tb/mulflag_unit_test.sv
module mulflag_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          op_signed = 1'b0;
  logic          op_form = 1'b0;
  logic          out_valid;
  logic [W-1:0]  res_lo;
  logic [W-1:0]  res_hi;
  logic [5:0]    res_flags;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulflag_unit #(.W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_signed (op_signed),
    .op_form   (op_form),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .res_flags (res_flags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent reference for one operation; returns lo, hi, flags
  task automatic model(input logic [31:0] a, input logic [31:0] b, input bit s, input bit f,
                       output logic [31:0] lo, output logic [31:0] hi, output logic [5:0] fl);
    longint sa, sb, p;
    bit sg, nofit, even;
    sg = s | f;
    sa = sg ? longint'($signed(a)) : longint'({32'd0, a});
    sb = sg ? longint'($signed(b)) : longint'({32'd0, b});
    p  = sa * sb;
    lo = p[31:0];
    hi = f ? 32'd0 : p[63:32];
    if (sg) nofit = (p != longint'($signed(p[31:0])));
    else    nofit = (p[63:32] != 32'd0);
    even = 1'b1;
    for (int i = 0; i < 8; i++) if (lo[i]) even = ~even;
    fl = {nofit, lo[31], (lo == 32'd0), 1'b0, even, nofit};
  endtask

  // Runs one operation; optionally keeps in_valid high with other operands while busy
  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input bit s, input bit f, input bit hold);
    logic [31:0] elo, ehi;
    logic [5:0]  efl;
    string rq;
    model(a, b, s, f, elo, ehi, efl);
    rq = f ? "R5" : (s ? "R3" : "R1");
    @(negedge clk);
    op_a = a; op_b = b; op_signed = s; op_form = f; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      op_a = ~a; op_b = b + 32'd3;
    end else begin
      in_valid = 1'b0;
    end
    check({"R8 busy ", tag}, {63'd0, in_ready}, 64'd0);
    check({"R8 no early strobe ", tag}, {63'd0, out_valid}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({"R8 strobe ", tag}, {63'd0, out_valid}, 64'd1);
    check({rq, " lo ", tag}, {32'd0, res_lo}, {32'd0, elo});
    check({rq, " hi ", tag}, {32'd0, res_hi}, {32'd0, ehi});
    check({(s | f) ? "R4" : "R2", " carry/ovf ", tag},
          {62'd0, res_flags[5], res_flags[0]}, {62'd0, efl[5], efl[0]});
    check({"R6 sign/zero/parity ", tag},
          {61'd0, res_flags[4], res_flags[3], res_flags[1]}, {61'd0, efl[4], efl[3], efl[1]});
    check({"R7 aux ", tag}, {63'd0, res_flags[2]}, 64'd0);
    @(negedge clk);
    check({"R8 strobe ends ", tag}, {63'd0, out_valid}, 64'd0);
    check({"R8 ready again ", tag}, {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 in_ready", {63'd0, in_ready}, 64'd1);
    check("R9 results", {res_hi, res_lo}, 64'd0);
    check("R9 flags", {58'd0, res_flags}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_unsigned();
    run_op("u max*max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    run_op("u 3*5", 32'd3, 32'd5, 1'b0, 1'b0, 1'b0);
    run_op("u 2^16*2^16", 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
    run_op("u zero", 32'd0, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    run_op("u 7*1 odd parity", 32'd7, 32'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_signed();
    run_op("s -1*-1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    run_op("s min*-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    run_op("s -3*7", 32'hFFFF_FFFD, 32'd7, 1'b1, 1'b0, 1'b0);
    run_op("s big neg", 32'h8000_0000, 32'd2, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_trunc();
    run_op("t unsigned-in -1*2", 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b1, 1'b0);
    run_op("t min*-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    run_op("t overflow", 32'h0001_0000, 32'h0001_0001, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_op("hold during busy", 32'd9, 32'd11, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_trunc();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule